// File: doc/BRIEF.md
# Three-Channel Programmable Clock Divider

The block divides one reference clock into three output clocks. Each output has its own 4-bit ratio code, and the ratio can be odd or even. Software-side logic writes two 8-bit control registers through a plain write port made of an address, a data byte and a strobe. A combinational read port returns either register. The registers hold the three ratio codes and two phase-inversion flags.

Every output keeps a 50% duty cycle, odd ratios included. A new code never cuts a period short: a channel switches to its new ratio only when its current output period ends. During reset each ratio field loads a default taken from a frequency-select input, so the outputs come up at a board-chosen rate and need no write first.

There is no streaming data path. All pins are plain control, status or clock pins with no handshake.

Top module: `cdiv_bank`

## Requirements
- R1: Channels 1 and 2 decode a code c[3:0] as base × 2^c[3:2], where the base is 2, 3, 5 or 7 for c[1:0] = 0, 1, 2 or 3. Each output period lasts that many reference cycles.
- R2: Channel 0 decodes the same way, except that c[1:0] = 0 gives base 4. Its codes x00 therefore give /4, /8, /16 and /32.
- R3: For every ratio N, odd or even, each output is high for N half reference cycles out of a 2N half-cycle period.
- R4: Register 0 holds the channel 0 code in bits 7:4 and the channel 1 code in bits 3:0. Register 1 holds the channel 2 code in bits 3:0. A write with `wr_en` high loads `wr_data` into the register chosen by `wr_addr` on that rising clock edge.
- R5: Bits 7:6 of register 1 read as zero whatever is written to them.
- R6: While `rst_n` is low, register 0 loads {fsel,2'b00,fsel,2'b00} and register 1 loads {4'h0,fsel,2'b00}. After reset every channel runs at its default ratio.
- R7: After a code write, the output period already in progress finishes with the old ratio. The period that starts at the next rising output edge uses the new ratio.
- R8: Register 1 bit 4 inverts output 1 and bit 5 inverts output 2. The inversion shows on the output right after the rising reference edge that stores the bit.
- R9: `rd_data` shows register `rd_addr` combinationally. The value read reflects each write from the edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fsel | input | 2 | Frequency select sampled during reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register select for writes |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Register select for reads |
| rd_data | output | 8 | Read data |
| clk_out | output | 3 | Divided output clocks |

## Verification
A register write shows on `rd_data` in the cycle after the edge that stores it, and an inversion flag shows on its output immediately after that same edge. The bench samples a short delay after each edge so that it sees both effects. A ratio change appears on the output only at the output's next rising edge. For this reason the bench measures periods between rising edges, in half-cycle samples. It reads the period that ends at the first rise after a write as the old ratio, and it checks the new ratio no earlier than the third rise. A register model in the bench is compared with `rd_data` on every clock.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  localparam int DATA_W = 8;
  localparam int CODE_W = 4;
  localparam int CNT_W  = 6;
  localparam int FSEL_W = 2;
  localparam int NUM_CH = 3;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [CNT_W-1:0]  ratio_t;

  // base factor from the low pair, power-of-two multiplier from the high pair
  function automatic ratio_t ratio_of(code_t code, logic alt);
    ratio_t base;
    unique case (code[1:0])
      2'd0:    base = alt ? ratio_t'(4) : ratio_t'(2);
      2'd1:    base = ratio_t'(3);
      2'd2:    base = ratio_t'(5);
      default: base = ratio_t'(7);
    endcase
    return base << code[3:2];
  endfunction

  function automatic code_t default_code(logic [FSEL_W-1:0] fs);
    return {fs, 2'b00};
  endfunction
endpackage

// File: rtl/cdiv_regs.sv
module cdiv_regs
  import cdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FSEL_W-1:0] fsel,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output code_t [NUM_CH-1:0] codes,
  output logic  [NUM_CH-1:0] inv
);
  localparam logic [DATA_W-1:0] R1_MASK = 8'h3F;

  logic [DATA_W-1:0] reg0_q, reg1_q;
  code_t dflt;

  assign dflt = default_code(fsel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg0_q <= {dflt, dflt};
      reg1_q <= {{(DATA_W-CODE_W){1'b0}}, dflt};
    end else if (wr_en) begin
      if (wr_addr) reg1_q <= wr_data & R1_MASK;
      else         reg0_q <= wr_data;
    end
  end

  assign rd_data  = rd_addr ? reg1_q : reg0_q;
  assign codes[0] = reg0_q[7:4];
  assign codes[1] = reg0_q[3:0];
  assign codes[2] = reg1_q[3:0];
  assign inv      = {reg1_q[5], reg1_q[4], 1'b0};
endmodule

// File: rtl/cdiv_chan.sv
module cdiv_chan
  import cdiv_pkg::*;
#(
  parameter bit ALT_DECODE = 1'b0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  code_t code_i,
  input  logic  inv_i,
  output logic  clk_o
);
  ratio_t cnt_q, ratio_q, cnt_inc, half_w;
  logic   lead_q, trail_q, raw_w, wrap_w;

  assign cnt_inc = cnt_q + ratio_t'(1);
  assign half_w  = ratio_q >> 1;
  assign wrap_w  = (cnt_inc == ratio_q);

  // rising edge of each output period is where a new ratio is adopted
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      lead_q  <= 1'b0;
      ratio_q <= ratio_of(code_i, ALT_DECODE);
    end else if (wrap_w) begin
      cnt_q   <= '0;
      lead_q  <= 1'b1;
      ratio_q <= ratio_of(code_i, ALT_DECODE);
    end else begin
      cnt_q   <= cnt_inc;
      lead_q  <= (cnt_inc < half_w);
    end
  end

  // half-cycle delayed copy stretches odd high phases by half a cycle
  always_ff @(negedge clk) begin
    if (!rst_n) trail_q <= 1'b0;
    else        trail_q <= lead_q;
  end

  assign raw_w = ratio_q[0] ? (lead_q | trail_q) : lead_q;
  assign clk_o = raw_w ^ inv_i;
endmodule

// File: rtl/cdiv_bank.sv
module cdiv_bank
  import cdiv_pkg::*;
(
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic [FSEL_W-1:0] fsel,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [NUM_CH-1:0] clk_out
);
  code_t [NUM_CH-1:0] code_w;
  logic  [NUM_CH-1:0] inv_w;

  cdiv_regs u_regs (
    .clk     (clk_ref),
    .rst_n   (rst_n),
    .fsel    (fsel),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .codes   (code_w),
    .inv     (inv_w)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    cdiv_chan #(.ALT_DECODE(i == 0)) u_ch (
      .clk    (clk_ref),
      .rst_n  (rst_n),
      .code_i (code_w[i]),
      .inv_i  (inv_w[i]),
      .clk_o  (clk_out[i])
    );
  end
endmodule

// File: rtl/cdiv_bank_chk.sv
module cdiv_bank_chk
  import cdiv_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [FSEL_W-1:0]  fsel,
  input logic               wr_en,
  input logic               wr_addr,
  input logic [DATA_W-1:0]  wr_data,
  input logic               rd_addr,
  input logic [DATA_W-1:0]  rd_data,
  input code_t [NUM_CH-1:0] codes,
  input logic  [NUM_CH-1:0] inv
);
  p_rsv_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr |-> (rd_data[7:6] == 2'b00));

  p_reset_dflt_r6: assert property (@(posedge clk)
    !rst_n |=> (codes[0] == {$past(fsel), 2'b00}) && (codes[2] == {$past(fsel), 2'b00}));

  p_wr_reg0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr) |=> (codes[0] == $past(wr_data[7:4])) && (codes[1] == $past(wr_data[3:0])));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(codes) && $stable(inv)));

  p_inv_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr) |=> (inv[2:1] == $past(wr_data[5:4])) && !inv[0]);
endmodule

bind cdiv_bank cdiv_bank_chk u_chk (
  .clk     (clk_ref),
  .rst_n   (rst_n),
  .fsel    (fsel),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .rd_addr (rd_addr),
  .rd_data (rd_data),
  .codes   (code_w),
  .inv     (inv_w)
);

// File: tb/cdiv_bank_test.sv
module cdiv_bank_test;
  logic       clk_ref = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] fsel = 2'd2;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_addr = 1'b0;
  logic [7:0] rd_data;
  logic [2:0] clk_out;

  int total = 0;
  int bad = 0;
  logic [7:0] mreg [2];
  bit mvalid = 1'b0;

  int halves = 0;
  int last_rise [3];
  int hcnt [3];
  int per_last [3];
  int high_last [3];
  int rises [3];
  logic prev [3];

  cdiv_bank uut (
    .clk_ref (clk_ref), .rst_n (rst_n), .fsel (fsel),
    .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
    .rd_addr (rd_addr), .rd_data (rd_data), .clk_out (clk_out)
  );

  always #4 clk_ref = ~clk_ref;

  function automatic int want_ratio(int code, bit alt);
    int bases [4] = '{2, 3, 5, 7};
    int b = bases[code % 4];
    if (alt && (code % 4) == 0) b = 4;
    return b * (1 << (code / 4));
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // half-cycle sampler for period and high time of every output
  initial begin
    for (int i = 0; i < 3; i++) begin
      last_rise[i] = 0; hcnt[i] = 0; per_last[i] = 0;
      high_last[i] = 0; rises[i] = 0; prev[i] = 1'b0;
    end
    forever begin
      @(posedge clk_ref or negedge clk_ref);
      #1;
      for (int i = 0; i < 3; i++) begin
        if (clk_out[i] && !prev[i]) begin
          per_last[i]  = halves - last_rise[i];
          high_last[i] = hcnt[i];
          hcnt[i]      = 1;
          last_rise[i] = halves;
          rises[i]++;
        end else if (clk_out[i]) hcnt[i]++;
        prev[i] = clk_out[i];
      end
      halves++;
    end
  end

  initial forever begin
    @(negedge clk_ref);
    rd_addr = ~rd_addr;
  end

  // register model compared with the read port on every clock (R9)
  always @(posedge clk_ref) begin
    #3;
    if (rst_n && mvalid) check(rd_data == mreg[rd_addr], "R9 readback", rd_data, mreg[rd_addr]);
  end

  task automatic do_reset(logic [1:0] fs);
    @(negedge clk_ref);
    rst_n = 1'b0; fsel = fs; mvalid = 1'b0;
    repeat (3) @(negedge clk_ref);
    mreg[0] = {fs, 2'b00, fs, 2'b00};
    mreg[1] = {4'h0, fs, 2'b00};
    rst_n = 1'b1; mvalid = 1'b1;
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk_ref);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk_ref);
    #1;
    mreg[a] = a ? (d & 8'h3F) : d;
    wr_en = 1'b0;
  endtask

  task automatic wait_rise(int ch, int target);
    while (rises[ch] < target) @(posedge clk_ref);
  endtask

  task automatic check_chan(int ch, int code, string req);
    int n = want_ratio(code, ch == 0);
    check(per_last[ch] == 2 * n, req, per_last[ch], 2 * n);
    check(high_last[ch] == n, "R3 duty", high_last[ch], n);
  endtask

  task automatic check_defaults(logic [1:0] fs);
    int b [3];
    for (int i = 0; i < 3; i++) b[i] = rises[i];
    for (int i = 0; i < 3; i++) begin
      wait_rise(i, b[i] + 3);
      check_chan(i, {fs, 2'b00}, "R6 default ratio");
    end
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset(2'd2);
    @(posedge clk_ref); #2;
    check(uut.rd_data == mreg[rd_addr], "R6 reset readback", rd_data, mreg[rd_addr]);
    check_defaults(2'd2);

    // R5: reserved bits
    wr(1'b1, 8'hFF);
    @(negedge clk_ref);
    rd_addr = 1'b1; #1;
    check(rd_data == 8'h3F, "R5 reserved bits", rd_data, 8'h3F);
    wr(1'b1, 8'h00);

    // R1 R2 R3 R4: every code on every channel
    for (int c = 0; c < 16; c++) begin
      int b [3];
      wr(1'b0, {c[3:0], c[3:0]});
      wr(1'b1, {4'h0, c[3:0]});
      for (int i = 0; i < 3; i++) b[i] = rises[i];
      for (int i = 0; i < 3; i++) begin
        wait_rise(i, b[i] + 3);
        check_chan(i, c, (i == 0) ? "R2 variant ratio" : "R1 ratio R4");
      end
    end

    // R7: change in mid-period on channel 0 (/7 -> /10)
    begin
      int b0;
      wr(1'b0, 8'h3C);
      b0 = rises[0];
      wait_rise(0, b0 + 3);
      wait_rise(0, rises[0] + 1);
      repeat (2) @(posedge clk_ref);
      wr(1'b0, 8'h6C);
      b0 = rises[0];
      wait_rise(0, b0 + 1);
      check(per_last[0] == 14, "R7 old period kept", per_last[0], 14);
      wait_rise(0, b0 + 3);
      check(per_last[0] == 20, "R7 new ratio", per_last[0], 20);
    end

    // R8: inversion during a long high phase (/16 on channels 1 and 2)
    wr(1'b1, 8'h0C);
    begin
      int b1 = rises[1];
      wait_rise(1, b1 + 3);
      wait_rise(1, rises[1] + 1);
      wr(1'b1, 8'h1C);
      #1;
      check(clk_out[1] == 1'b0, "R8 invert out1", clk_out[1], 0);
      wr(1'b1, 8'h0C);
      #1;
      check(clk_out[1] == 1'b1, "R8 restore out1", clk_out[1], 1);
      wait_rise(2, rises[2] + 1);
      wr(1'b1, 8'h2C);
      #1;
      check(clk_out[2] == 1'b0, "R8 invert out2", clk_out[2], 0);
      wr(1'b1, 8'h0C);
    end

    // R6: second reset with another select value
    do_reset(2'd3);
    @(posedge clk_ref); #2;
    check(mreg[0] == 8'hCC, "R6 model", mreg[0], 8'hCC);
    check_defaults(2'd3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule